// File: doc/BRIEF.md
# CAN Receive Bit Destuffer With Fixed-Interval Mode

This block sits behind the bit sampler of a CAN / CAN FD receiver and classifies every received bit as either payload or stuff. It looks at the incoming serial line only on cycles where the sample-point strobe is high, taking one bit per strobe. In the normal (dynamic) rule, a bit that follows a run of `stuff_len` equal bits is a stuff bit. Such a bit is flagged and counted, and a stuff error is raised if it repeats the run polarity.

When the fixed-mode input rises, the block changes to the fixed-interval rule used for the FD CRC field. The bit taken with the rising edge is itself a stuff bit. After that, one stuff bit is expected after every `stuff_len` payload bits, whatever their values. Each expected stuff bit must be the inverse of the bit before it. Where the first fixed stuff bit lands on a position that the dynamic rule would also claim, the fixed rule wins.

A wrapping counter of dynamically removed stuff bits is kept for the stuff-count field of the FD frame. The downstream frame decoder reads the registered data bit and the stuff flag and skips the flagged bits.

Top module: `cbd_destuffer`

## Requirements
- R1: While `sample_strobe` is low, `rx_bit`, `fixed_mode` and `stuff_len` have no effect: `data_out`, `destuffed` and `dyn_count` keep their values.
- R2: In dynamic mode (`fixed_mode` low), a bit taken after a run of exactly `stuff_len` equal bits is marked with `destuffed` = 1. All other bits give `destuffed` = 0.
- R3: In dynamic mode, if that stuff-position bit has the same polarity as the run (stuff_len+1 equal bits), `stuff_err` is raised together with `destuffed`.
- R4: After any stuff bit, the equal-polarity run restarts at length 1, with the stuff bit's own value as the run polarity.
- R5: `dyn_count` increments by one for each dynamic stuff bit and wraps modulo 2^CNT_W. Fixed stuff bits do not change it.
- R6: The strobe on which `fixed_mode` is first seen high after being low (or after enable) takes a fixed stuff bit. `stuff_err` is raised if that bit equals the bit before it.
- R7: While `fixed_mode` stays high, the dynamic rule is off. The bit after every `stuff_len` payload bits is a fixed stuff bit, and `stuff_err` is raised if it equals the preceding bit.
- R8: When the `fixed_mode` rising edge coincides with a dynamic stuff position, the bit is treated as a fixed stuff bit: `destuffed` = 1 and `dyn_count` unchanged.
- R9: While `enable` is low, `dyn_count`, `destuffed` and `stuff_err` are 0, `data_out` is 1, and all run, interval and edge state is cleared.
- R10: Outputs are registered: a bit taken on a strobe appears on `data_out` / `destuffed` after that clock edge. `stuff_err` is high only in the cycle following a strobe.
- R11: After reset, `data_out` = 1, `destuffed` = 0, `stuff_err` = 0 and `dyn_count` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Block enable; low clears all state |
| sample_strobe | input | 1 | Sample-point strobe; one bit taken per high cycle |
| rx_bit | input | 1 | Received bit value |
| stuff_len | input | LEN_W | Stuff run length (2 to 2^LEN_W-1) |
| fixed_mode | input | 1 | High selects the fixed-interval rule; rising edge starts it |
| data_out | output | 1 | Last taken bit |
| destuffed | output | 1 | Last taken bit was a stuff bit |
| stuff_err | output | 1 | Stuff rule violated by the last taken bit |
| dyn_count | output | CNT_W | Wrapping count of dynamic stuff bits |

## Verification
The critical collision is a dynamic stuff position and a fixed-mode rising edge falling on the same strobe. The bench provokes it by sending a run of exactly `stuff_len` equal bits, then raising `fixed_mode` with an opposite bit. It then expects `destuffed` high, no error, and `dyn_count` unchanged. A second coincidence, a stuff position and a polarity error on one bit, is exercised in both the dynamic and fixed rules. A behavioural model keeps a queue of bits since the last stuff bit and compares all outputs on every clock. It does this through a long pseudo-random stream with mode toggles, length changes and enable drops.

// File: rtl/cbd_pkg.sv
package cbd_pkg;

  localparam int unsigned CBD_LEN_W_DEF = 3;
  localparam int unsigned CBD_CNT_W_DEF = 3;

  typedef enum logic [1:0] {
    BK_DATA = 2'd0,
    BK_DYN  = 2'd1,
    BK_FIX  = 2'd2
  } bit_kind_e;

  // Fixed rule owns the bit whenever fixed mode is on (gives it priority).
  function automatic bit_kind_e classify(input logic fixed_on,
                                         input logic fix_hit,
                                         input logic dyn_hit);
    if (fixed_on) return fix_hit ? BK_FIX : BK_DATA;
    return dyn_hit ? BK_DYN : BK_DATA;
  endfunction

  // A stuff bit must invert the bit before it.
  function automatic logic polarity_bad(input logic have_prev,
                                        input logic bit_now,
                                        input logic bit_last);
    return have_prev && (bit_now == bit_last);
  endfunction

endpackage

// File: rtl/cbd_fix_edge.sv
module cbd_fix_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic take,
  input  logic level,
  output logic rise
);
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      seen_q <= 1'b0;
    else if (clr)    seen_q <= 1'b0;
    else if (take)   seen_q <= level;
  end

  assign rise = level & ~seen_q;
endmodule

// File: rtl/cbd_run_track.sv
module cbd_run_track #(
  parameter int unsigned RUN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             take,
  input  logic             bit_in,
  input  logic             restart,
  output logic [RUN_W-1:0] run_len,
  output logic             run_pol,
  output logic             have_prev
);
  localparam logic [RUN_W-1:0] RUN_MAX = {RUN_W{1'b1}};
  localparam logic [RUN_W-1:0] RUN_ONE = RUN_W'(1);

  function automatic logic [RUN_W-1:0] sat_inc(input logic [RUN_W-1:0] v);
    return (v == RUN_MAX) ? v : v + RUN_ONE;
  endfunction

  logic [RUN_W-1:0] len_q;
  logic             pol_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      pol_q <= 1'b1;
    end else if (clr) begin
      len_q <= '0;
      pol_q <= 1'b1;
    end else if (take) begin
      if (restart || (len_q == '0) || (bit_in != pol_q)) begin
        len_q <= RUN_ONE;
        pol_q <= bit_in;
      end else begin
        len_q <= sat_inc(len_q);
      end
    end
  end

  assign run_len   = len_q;
  assign run_pol   = pol_q;
  assign have_prev = (len_q != '0);
endmodule

// File: rtl/cbd_fix_count.sv
module cbd_fix_count #(
  parameter int unsigned LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             take,
  input  logic             fixed_on,
  input  logic             stuff_now,
  output logic [LEN_W-1:0] data_since
);
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (clr)            cnt_q <= '0;
    else if (take) begin
      if (!fixed_on)         cnt_q <= '0;
      else if (stuff_now)    cnt_q <= '0;
      else                   cnt_q <= cnt_q + LEN_W'(1);
    end
  end

  assign data_since = cnt_q;
endmodule

// File: rtl/cbd_destuffer.sv
module cbd_destuffer
  import cbd_pkg::*;
#(
  parameter int unsigned LEN_W = CBD_LEN_W_DEF,
  parameter int unsigned CNT_W = CBD_CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             sample_strobe,
  input  logic             rx_bit,
  input  logic [LEN_W-1:0] stuff_len,
  input  logic             fixed_mode,
  output logic             data_out,
  output logic             destuffed,
  output logic             stuff_err,
  output logic [CNT_W-1:0] dyn_count
);
  localparam int unsigned RUN_W = LEN_W + 1;

  // Named internal events, visible to the bound checker.
  logic             take_bit;
  logic             clr_all;
  logic             fix_rise;
  logic [RUN_W-1:0] run_len;
  logic             run_pol;
  logic             have_prev;
  logic [LEN_W-1:0] fix_since;
  logic             dyn_hit;
  logic             fix_hit;
  bit_kind_e        kind;
  logic             is_stuff;
  logic             rule_broken;
  logic             dyn_removed;

  assign take_bit = enable & sample_strobe;
  assign clr_all  = ~enable;

  cbd_fix_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr_all),
    .take  (take_bit),
    .level (fixed_mode),
    .rise  (fix_rise)
  );

  cbd_run_track #(.RUN_W(RUN_W)) u_run (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr_all),
    .take      (take_bit),
    .bit_in    (rx_bit),
    .restart   (is_stuff),
    .run_len   (run_len),
    .run_pol   (run_pol),
    .have_prev (have_prev)
  );

  cbd_fix_count #(.LEN_W(LEN_W)) u_fix (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr_all),
    .take       (take_bit),
    .fixed_on   (fixed_mode),
    .stuff_now  (is_stuff),
    .data_since (fix_since)
  );

  assign dyn_hit     = have_prev && (run_len == {1'b0, stuff_len});
  assign fix_hit     = fix_rise || (fix_since == stuff_len);
  assign kind        = classify(fixed_mode, fix_hit, dyn_hit);
  assign is_stuff    = (kind != BK_DATA);
  assign rule_broken = is_stuff && polarity_bad(have_prev, rx_bit, run_pol);
  assign dyn_removed = take_bit && (kind == BK_DYN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_out  <= 1'b1;
      destuffed <= 1'b0;
      stuff_err <= 1'b0;
      dyn_count <= '0;
    end else if (clr_all) begin
      data_out  <= 1'b1;
      destuffed <= 1'b0;
      stuff_err <= 1'b0;
      dyn_count <= '0;
    end else if (take_bit) begin
      data_out  <= rx_bit;
      destuffed <= is_stuff;
      stuff_err <= rule_broken;
      if (dyn_removed) dyn_count <= dyn_count + CNT_W'(1);
    end else begin
      stuff_err <= 1'b0;
    end
  end
endmodule

// File: rtl/cbd_destuffer_chk.sv
module cbd_destuffer_chk #(
  parameter int unsigned CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             sample_strobe,
  input logic             fixed_mode,
  input logic             take_bit,
  input logic             data_out,
  input logic             destuffed,
  input logic             stuff_err,
  input logic [CNT_W-1:0] dyn_count
);
  // R1
  hold_without_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !sample_strobe) |=> ($stable(data_out) && $stable(destuffed) && $stable(dyn_count)));

  // R9
  disabled_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (dyn_count == '0 && !destuffed && !stuff_err && data_out));

  // R10
  err_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_err |-> $past(take_bit));

  // R3
  err_on_stuff_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_err |-> destuffed);

  // R5
  count_single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(enable) && dyn_count != $past(dyn_count)) |-> (dyn_count == $past(dyn_count) + CNT_W'(1)));

  // R8
  fixed_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_bit && fixed_mode) |=> $stable(dyn_count));
endmodule

bind cbd_destuffer cbd_destuffer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .enable        (enable),
  .sample_strobe (sample_strobe),
  .fixed_mode    (fixed_mode),
  .take_bit      (take_bit),
  .data_out      (data_out),
  .destuffed     (destuffed),
  .stuff_err     (stuff_err),
  .dyn_count     (dyn_count)
);

// File: tb/cbd_destuffer_tb_top.sv
`timescale 1ns/1ps
module cbd_destuffer_tb_top;
  localparam int unsigned LEN_W = 3;
  localparam int unsigned CNT_W = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             enable = 1'b0;
  logic             sample_strobe = 1'b0;
  logic             rx_bit = 1'b1;
  logic [LEN_W-1:0] stuff_len = 3'd4;
  logic             fixed_mode = 1'b0;
  logic             data_out;
  logic             destuffed;
  logic             stuff_err;
  logic [CNT_W-1:0] dyn_count;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #4 clk = ~clk;

  cbd_destuffer #(.LEN_W(LEN_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sample_strobe(sample_strobe),
    .rx_bit(rx_bit), .stuff_len(stuff_len), .fixed_mode(fixed_mode),
    .data_out(data_out), .destuffed(destuffed), .stuff_err(stuff_err),
    .dyn_count(dyn_count)
  );

  // Behavioural reference: queue of bits since the last stuff bit.
  bit hist[$];
  bit m_fprev  = 0;
  int m_fixcnt = 0;
  bit m_data   = 1;
  bit m_dst    = 0;
  bit m_err    = 0;
  int m_cnt    = 0;

  always @(posedge clk) begin
    if (!rst_n || !enable) begin
      hist.delete();
      m_fprev = 0; m_fixcnt = 0;
      m_data = 1; m_dst = 0; m_err = 0; m_cnt = 0;
    end else if (sample_strobe) begin
      bit have, last, rise, stf, dyn;
      int run, len;
      len  = int'(stuff_len);
      have = (hist.size() > 0);
      last = have ? hist[hist.size()-1] : 1'b1;
      run  = 0;
      if (have) begin
        for (int i = hist.size()-1; i >= 0; i--) begin
          if (hist[i] != last) break;
          run++;
        end
      end
      rise = fixed_mode && !m_fprev;
      m_fprev = fixed_mode;
      if (fixed_mode) begin
        stf = rise || (m_fixcnt == len);
        dyn = 0;
        m_fixcnt = stf ? 0 : m_fixcnt + 1;
      end else begin
        stf = have && (run == len);
        dyn = stf;
        m_fixcnt = 0;
      end
      m_err  = stf && have && (rx_bit == last);
      m_dst  = stf;
      m_data = rx_bit;
      if (dyn) m_cnt = (m_cnt + 1) % (1 << CNT_W);
      if (stf) hist.delete();
      hist.push_back(rx_bit);
      if (hist.size() > 32) void'(hist.pop_front());
    end else begin
      m_err = 0;
    end
  end

  // Every-clock comparison with the model (R10 covers registered timing).
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_checks++;
      if (data_out !== m_data || destuffed !== m_dst || stuff_err !== m_err ||
          int'(dyn_count) != m_cnt) begin
        n_fail++;
        $display("FAIL R10 model compare t=%0t act d=%0b s=%0b e=%0b c=%0d exp d=%0b s=%0b e=%0b c=%0d",
                 $time, data_out, destuffed, stuff_err, dyn_count, m_data, m_dst, m_err, m_cnt);
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input bit b);
    @(negedge clk);
    sample_strobe = 1'b1;
    rx_bit = b;
    @(negedge clk);
    sample_strobe = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int lfsr;
    bit prev;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R11 reset state
    check("R11 data_out", data_out, 1);
    check("R11 destuffed", destuffed, 0);
    check("R11 stuff_err", stuff_err, 0);
    check("R11 dyn_count", dyn_count, 0);

    enable = 1'b1;
    stuff_len = 3'd4;
    // R2: four zeros then a one is a stuff bit
    send(0); send(0); send(0); send(0);
    check("R2 no stuff inside run", destuffed, 0);
    send(1);
    check("R2 stuff flagged", destuffed, 1);
    check("R2 no error", stuff_err, 0);
    check("R5 count after first", dyn_count, 1);

    // R4: run restarts from the stuff bit value
    send(1); send(1); send(1);
    check("R4 still data", destuffed, 0);
    send(0);
    check("R4 stuff after restarted run", destuffed, 1);
    check("R5 count two", dyn_count, 2);

    // R3: five equal bits
    send(0); send(0); send(0);
    send(0);
    check("R3 stuff position", destuffed, 1);
    check("R3 error raised", stuff_err, 1);
    idle(1);
    check("R10 error is a pulse", stuff_err, 0);

    // R1: line toggles without strobe
    for (int i = 0; i < 6; i++) begin
      rx_bit = i[0];
      fixed_mode = ~i[0];
      @(negedge clk);
    end
    fixed_mode = 1'b0;
    check("R1 data held", data_out, 0);
    check("R1 count held", dyn_count, 3);

    // R5 wrap with length 2
    stuff_len = 3'd2;
    for (int k = 0; k < 5; k++) begin
      send(k[0]);
      send(~k[0]);
    end
    check("R5 wrap to zero", dyn_count, 0);

    // R8: dynamic stuff position meets fixed edge
    stuff_len = 3'd4;
    send(1); send(1); send(1);
    @(negedge clk);
    fixed_mode = 1'b1;
    send(0);
    check("R8 flagged as stuff", destuffed, 1);
    check("R8 no error", stuff_err, 0);
    check("R8 count unchanged", dyn_count, 0);

    // R7: fixed interval, no dynamic rule
    send(0); send(0); send(0); send(0);
    check("R7 no dynamic stuff in fixed", destuffed, 0);
    check("R7 no dynamic error in fixed", stuff_err, 0);
    send(0);
    check("R7 fixed stuff flagged", destuffed, 1);
    check("R7 fixed polarity error", stuff_err, 1);
    check("R7 count unchanged", dyn_count, 0);

    // R6: fixed edge with same polarity, then proper inversion
    @(negedge clk); fixed_mode = 1'b0;
    send(1);
    @(negedge clk); fixed_mode = 1'b1;
    send(1);
    check("R6 edge stuff", destuffed, 1);
    check("R6 edge same polarity error", stuff_err, 1);
    @(negedge clk); fixed_mode = 1'b0;
    send(0);
    @(negedge clk); fixed_mode = 1'b1;
    send(1);
    check("R6 edge good stuff", destuffed, 1);
    check("R6 edge no error", stuff_err, 0);

    // R9: disable clears
    @(negedge clk); fixed_mode = 1'b0;
    stuff_len = 3'd2;
    send(0); send(0); send(1);
    check("R9 precondition count", dyn_count, 1);
    enable = 1'b0;
    idle(2);
    check("R9 count cleared", dyn_count, 0);
    check("R9 data recessive", data_out, 1);
    send(0);
    check("R9 strobe ignored", data_out, 1);
    enable = 1'b1;

    // Long pseudo-random stream against the model
    lfsr = 16'hACE1;
    prev = 0;
    for (int n = 0; n < 4000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]} & 16'hFFFF;
      if (n % 300 == 150 && !fixed_mode) stuff_len = LEN_W'(2 + (lfsr % 6));
      if (n % 211 == 100) fixed_mode = ~fixed_mode;
      if (n % 733 == 500) begin enable = 1'b0; idle(1); enable = 1'b1; end
      if ((lfsr & 3) == 0) prev = ~prev;
      send(prev);
      if (lfsr[5]) idle(1);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule